// File: doc/BRIEF.md
# Interrupt Status and Mask Register Group

This block collects interrupt events from a small set of hardware sources into a status register and drives one level-sensitive interrupt line. A host reaches it through a plain 32-bit register port with a word address. It reads the pending sources, acknowledges them by writing ones, and controls which sources may raise the line.

The mask register cannot be written at its own address. It changes only through two write-only strobe addresses: one clears mask bits (unmasks sources) and one sets mask bits (masks sources). Both strobe addresses read back as zero. After reset every source is masked. The interrupt output is registered. It is computed from the next-state status and mask, so it follows every change on the same clock edge that updates the registers.

Word offsets: 0 is status, 1 is mask, 2 is enable (clear mask), and 3 is disable (set mask). All other offsets are undefined.

Top module: `irq_status_mask_regs`

## Requirements
- R1: `irq` is high exactly when some status bit is 1 and its mask bit is 0. It reflects register contents in the cycle after the edge that changed them.
- R2: A full-word write to offset 0 clears each status bit written as 1. Status bits written as 0 keep their value.
- R3: After reset, status reads 0, mask reads all ones over the NUM_SRC source bits, and `irq` is 0.
- R4: A write to offset 1 (mask) leaves the mask unchanged.
- R5: A full-word write to offset 2 clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A full-word write to offset 3 sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R7: Reads of offsets 2 and 3 return zero.
- R8: A 1 on `srcSet[i]` sets status bit i. This has priority over a clearing write to the same bit in the same cycle.
- R9: A write with any `byteEn` bit low is ignored: status and mask are unchanged.
- R10: Offsets 4 and above read zero, and writes to them change neither status nor mask.
- R11: In status and mask reads, the bits at and above NUM_SRC read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Word address for read and write |
| wrData | input | 32 | Write data |
| byteEn | input | 4 | Byte enables; only 4'hF is accepted |
| rdData | output | 32 | Combinational read data for `addr` |
| srcSet | input | NUM_SRC | Per-source event pulse |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with NUM_SRC = 3 and ADDR_W = 4. With three sources, every combination of status pattern and mask pattern (64 pairs) can be swept, and for each pair every clearing pattern can be applied. The expected status, mask and `irq` are computed arithmetically in the bench. A 4-bit word address makes the whole undefined range 4..15 small enough to read and write exhaustively.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned BE_W        = WORD_W / 8;
  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_MASK    = 1;
  localparam int unsigned OFS_ENABLE  = 2;
  localparam int unsigned OFS_DISABLE = 3;

  typedef struct packed {
    logic clrStatus;
    logic clrMask;
    logic setMask;
  } irqStrobe_t;
endpackage

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl
  import irq_grp_pkg::*;
#(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BE_W-1:0]     byteEn,
  input  logic [NUM_SRC-1:0]  statusVal,
  input  logic [NUM_SRC-1:0]  maskVal,
  output irqStrobe_t          strobe,
  output logic [WORD_W-1:0]   rdData
);
  logic fullWr;
  logic hitStatus, hitMask;

  assign fullWr    = wrEn && (byteEn == {BE_W{1'b1}});
  assign hitStatus = (addr == ADDR_W'(OFS_STATUS));
  assign hitMask   = (addr == ADDR_W'(OFS_MASK));

  always_comb begin
    strobe.clrStatus = fullWr && hitStatus;
    strobe.clrMask   = fullWr && (addr == ADDR_W'(OFS_ENABLE));
    strobe.setMask   = fullWr && (addr == ADDR_W'(OFS_DISABLE));
  end

  always_comb begin
    rdData = '0;
    if (hitStatus)    rdData[NUM_SRC-1:0] = statusVal;
    else if (hitMask) rdData[NUM_SRC-1:0] = maskVal;
  end
endmodule

// File: rtl/irq_grp_dp.sv
module irq_grp_dp
  import irq_grp_pkg::*;
#(
  parameter int unsigned          NUM_SRC  = 1,
  parameter logic [NUM_SRC-1:0]   MASK_RST = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  irqStrobe_t          strobe,
  input  logic [NUM_SRC-1:0]  wrBits,
  input  logic [NUM_SRC-1:0]  srcSet,
  output logic [NUM_SRC-1:0]  statusVal,
  output logic [NUM_SRC-1:0]  maskVal,
  output logic                irq
);
  logic [NUM_SRC-1:0] statusQ, statusNext;
  logic [NUM_SRC-1:0] maskQ, maskNext;
  logic               irqQ;

  always_comb begin
    statusNext = statusQ;
    if (strobe.clrStatus) statusNext = statusQ & ~wrBits;
    statusNext = statusNext | srcSet;
  end

  always_comb begin
    maskNext = maskQ;
    if (strobe.clrMask)      maskNext = maskQ & ~wrBits;
    else if (strobe.setMask) maskNext = maskQ | wrBits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= MASK_RST;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqQ    <= |(statusNext & ~maskNext);
    end
  end

  assign statusVal = statusQ;
  assign maskVal   = maskQ;
  assign irq       = irqQ;
endmodule

// File: rtl/irq_status_mask_regs.sv
module irq_status_mask_regs
  import irq_grp_pkg::*;
#(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  input  logic [3:0]          byteEn,
  output logic [31:0]         rdData,
  input  logic [NUM_SRC-1:0]  srcSet,
  output logic                irq
);
  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] statusVal, maskVal;

  irq_grp_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) ctrl_i (
    .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .statusVal(statusVal), .maskVal(maskVal),
    .strobe(strobe), .rdData(rdData)
  );

  irq_grp_dp #(.NUM_SRC(NUM_SRC), .MASK_RST({NUM_SRC{1'b1}})) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrBits(wrData[NUM_SRC-1:0]), .srcSet(srcSet),
    .statusVal(statusVal), .maskVal(maskVal), .irq(irq)
  );
endmodule

// File: rtl/irq_grp_chk.sv
module irq_grp_chk #(
  parameter int unsigned NUM_SRC = 1,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wrData,
  input logic [3:0]         byteEn,
  input logic [31:0]        rdData,
  input logic [NUM_SRC-1:0] srcSet,
  input logic               irq,
  input logic [NUM_SRC-1:0] statusVal,
  input logic [NUM_SRC-1:0] maskVal
);
  logic fullWr;
  assign fullWr = wrEn && (byteEn == 4'hF);

  p_irq_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(statusVal & ~maskVal));

  p_clear_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fullWr && addr == ADDR_W'(0) && wrData[0] && !srcSet[0]) |=> !statusVal[0]);

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fullWr && (addr == ADDR_W'(2) || addr == ADDR_W'(3))) |=> $stable(maskVal));

  p_unmask_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fullWr && addr == ADDR_W'(2) && wrData[0]) |=> !maskVal[0]);

  p_mask_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fullWr && addr == ADDR_W'(3) && wrData[0]) |=> maskVal[0]);

  p_strobe_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(2) || addr == ADDR_W'(3)) |-> rdData == 32'd0);

  p_src_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srcSet[0] |=> statusVal[0]);

  p_partial_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && byteEn != 4'hF && srcSet == '0) |=> ($stable(maskVal) && $stable(statusVal)));
endmodule

bind irq_status_mask_regs irq_grp_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .byteEn(byteEn), .rdData(rdData), .srcSet(srcSet), .irq(irq),
  .statusVal(statusVal), .maskVal(maskVal)
);

// File: tb/irq_status_mask_regs_tb.sv
module irq_status_mask_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 3;
  localparam int AW   = 4;
  localparam logic [31:0] ALL = (32'd1 << NSRC) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [3:0] byteEn = 4'hF;
  logic [31:0] rdData;
  logic [NSRC-1:0] srcSet = '0;
  logic irq;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_mask_regs #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .byteEn(byteEn), .rdData(rdData), .srcSet(srcSet), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be,
                         input logic [NSRC-1:0] src);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; byteEn = be; srcSet = src;
    @(negedge clk);
    wrEn = 1'b0; srcSet = '0; byteEn = 4'hF;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulse(input logic [NSRC-1:0] src);
    @(negedge clk);
    srcSet = src;
    @(negedge clk);
    srcSet = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, s0, m0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    doRead(0, r); check("R3 status reset", r, 32'd0);
    doRead(1, r); check("R3 mask reset", r, ALL);
    check("R3 irq reset", {31'd0, irq}, 32'd0);
    doRead(2, r); check("R7 enable reads zero", r, 32'd0);
    doRead(3, r); check("R7 disable reads zero", r, 32'd0);

    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int c = 0; c < 8; c++) begin
          doWrite(0, ALL, 4'hF, '0);
          doWrite(3, ALL, 4'hF, '0);
          doWrite(2, ~m & ALL, 4'hF, '0);
          doRead(1, r); check("R5 enable clears mask bits", r, m);
          check("R11 mask upper bits", r & ~ALL, 32'd0);
          pulse(s[NSRC-1:0]);
          doRead(0, r); check("R8 source sets status", r, s);
          check("R11 status upper bits", r & ~ALL, 32'd0);
          check("R1 irq level", {31'd0, irq}, {31'd0, |(s & ~m & 7)});
          doWrite(0, c, 4'hF, '0);
          doRead(0, r); check("R2 w1c status", r, s & ~c & 7);
          check("R1 irq after clear", {31'd0, irq}, {31'd0, |(s & ~c & ~m & 7)});
        end
      end
    end

    doWrite(0, ALL, 4'hF, '0);
    doWrite(3, ALL, 4'hF, '0);
    doWrite(2, 32'h2, 4'hF, '0);
    doWrite(3, 32'h4, 4'hF, '0);
    doRead(1, r); check("R6 disable sets only written bits", r, 32'h5);
    doWrite(3, 32'h2, 4'hF, '0);
    doRead(1, r); check("R6 disable sets bit1", r, 32'h7);
    check("R1 irq masked", {31'd0, irq}, 32'd0);

    doWrite(2, 32'h7, 4'hF, '0);
    doWrite(1, 32'h7, 4'hF, '0);
    doRead(1, r); check("R4 direct mask write ignored", r, 32'd0);

    pulse(3'b011);
    doWrite(0, 32'h3, 4'hF, 3'b010);
    doRead(0, r); check("R8 set beats clear", r, 32'h2);
    check("R1 irq with set winning", {31'd0, irq}, 32'd1);

    doWrite(0, 32'h2, 4'h7, '0);
    doRead(0, r); check("R9 partial status write ignored", r, 32'h2);
    doWrite(3, 32'h7, 4'hE, '0);
    doRead(1, r); check("R9 partial disable ignored", r, 32'd0);
    doWrite(2, 32'h7, 4'h0, '0);
    doWrite(3, 32'h7, 4'hF, '0);
    doWrite(2, 32'h1, 4'h1, '0);
    doRead(1, r); check("R9 partial enable ignored", r, 32'h7);
    doWrite(2, 32'h7, 4'hF, '0);

    doRead(0, s0); doRead(1, m0);
    for (int a = 4; a < 16; a++) begin
      doWrite(a[AW-1:0], 32'hFFFF_FFFF, 4'hF, '0);
      doRead(a[AW-1:0], r); check("R10 undefined offset reads zero", r, 32'd0);
    end
    doRead(0, r); check("R10 status untouched", r, s0);
    doRead(1, r); check("R10 mask untouched", r, m0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule